// File: doc/BRIEF.md
# Primary Interrupt Status Aggregator

This block sits at the top of a two-level interrupt tree. Up to eight secondary interrupt modules each present a request for each of two host-facing interrupt lines. The block merges them into one status byte per line. Bit n of each byte shows that secondary module n is requesting on that line. Each line drives its own active-low interrupt output, so two independent hosts can each see their own view.

A secondary module may have only one request output. In that case its single request is routed into both status bytes. Module slots can be declared absent at elaboration. An absent slot always reads as zero and can never raise an interrupt.

A small byte-addressed register port gives read access to both status bytes. It also gives read and write access to a test register, which forces module bits high in both bytes so that the interrupt path can be exercised without the secondary modules.

Top module: `pri_irq_agg`

## Requirements
- R1: After reset both `int1_n` and `int2_n` are high, and the test register (offset 0x03) reads 0x00.
- R2: Offset 0x01 reads the line-1 status byte. Bit n is 1 while present module n drives its line-1 request (`line1_req[n]`). The byte is live, not latched, so it drops in the same cycle the request drops.
- R3: Offset 0x02 reads the line-2 status byte. For a present two-line module, bit n follows `line2_req[n]`.
- R4: For a present module whose `ONE_LINE` bit is 1 (bit 6 by default), `line1_req[n]` sets bit n in both status bytes, and `line2_req[n]` has no effect.
- R5: For a slot whose `PRESENT` bit is 0 (slot 7 by default), bit n reads 0 in both status bytes and in the test register, whatever its request inputs are. Such a slot never pulls either interrupt output low.
- R6: Writing the test register at offset 0x03 stores the written byte, masked to the present slots. Each stored 1 forces the matching bit high in both status bytes until that bit is written back to 0. A read of 0x03 returns the stored value.
- R7: Each `intN_n` output is registered. It goes low on the first rising edge at which its status byte is nonzero, and returns high on the first rising edge at which its status byte is zero.
- R8: Reads of any offset other than 0x01, 0x02 and 0x03 return 0x00. Writes to 0x01, 0x02 or any unmapped offset change no state.
- R9: The two lines are independent. A request present only on line 2 pulls `int2_n` low and leaves `int1_n` high, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line1_req | input | NUM_MODS | Per-module request toward line 1 |
| line2_req | input | NUM_MODS | Per-module request toward line 2 |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| int1_n | output | 1 | Active-low interrupt for line 1 |
| int2_n | output | 1 | Active-low interrupt for line 2 |

## Verification
The output-timing properties assume that the request inputs and the register-port inputs are synchronous to `clk` and settle before each rising edge. The stimulus meets this by changing every input only on falling edges, well clear of the sampling edge.

The test-register hold property assumes that `reg_wr` is low whenever no store is intended. The stimulus keeps the strobe high for exactly one cycle per write.

The mirror and absent-slot properties take the `PRESENT` and `ONE_LINE` parameters as fixed. The bench uses only the default values of these parameters.

// File: rtl/pia_pkg.sv
`timescale 1ns/1ps
package pia_pkg;
   // Register offsets of the host port; the status offsets order the lines.
   localparam int unsigned OFS_STAT1 = 1;
   localparam int unsigned OFS_STAT2 = 2;
   localparam int unsigned OFS_FORCE = 3;
   localparam int unsigned MAX_MODS  = 8;
endpackage

// File: rtl/pia_line_merge.sv
`timescale 1ns/1ps
module pia_line_merge #(
   parameter int unsigned           NUM_MODS = 8,
   parameter logic [NUM_MODS-1:0]   PRESENT  = '1,
   parameter logic [NUM_MODS-1:0]   ONE_LINE = '0
) (
   input  logic [NUM_MODS-1:0] req1_i,
   input  logic [NUM_MODS-1:0] req2_i,
   input  logic [NUM_MODS-1:0] force_i,
   output logic [NUM_MODS-1:0] stat1_o,
   output logic [NUM_MODS-1:0] stat2_o
);
   // line-2 inputs of single-line and absent slots are not routed anywhere
   logic unused_req2;
   assign unused_req2 = ^(req2_i & ~(PRESENT & ~ONE_LINE));

   for (genvar g = 0; g < NUM_MODS; g++) begin : g_slot
      if (!PRESENT[g]) begin : g_absent
         assign stat1_o[g] = 1'b0;
         assign stat2_o[g] = 1'b0;
      end else if (ONE_LINE[g]) begin : g_single
         assign stat1_o[g] = req1_i[g] | force_i[g];
         assign stat2_o[g] = req1_i[g] | force_i[g];
      end else begin : g_dual
         assign stat1_o[g] = req1_i[g] | force_i[g];
         assign stat2_o[g] = req2_i[g] | force_i[g];
      end
   end
endmodule

// File: rtl/pia_force_reg.sv
`timescale 1ns/1ps
module pia_force_reg #(
   parameter int unsigned         NUM_MODS = 8,
   parameter int unsigned         DATA_W   = 8,
   parameter logic [NUM_MODS-1:0] PRESENT  = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [NUM_MODS-1:0] force_o
);
   logic [NUM_MODS-1:0] force_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       force_q <= '0;
      else if (wr_en_i) force_q <= wdata_i[NUM_MODS-1:0] & PRESENT;
   end
   assign force_o = force_q;

   if (NUM_MODS < DATA_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:NUM_MODS];
   end

   // R6
   force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(force_q));
endmodule

// File: rtl/pia_irq_out.sv
`timescale 1ns/1ps
module pia_irq_out #(
   parameter int unsigned NUM_MODS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_MODS-1:0] stat_i,
   output logic                irq_n_o
);
   logic irq_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~(|stat_i);
   end
   assign irq_n_o = irq_n_q;

   // R7
   irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|stat_i) |=> !irq_n_o);
   // R7
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|stat_i) |=> irq_n_o);
endmodule

// File: rtl/pri_irq_agg.sv
`timescale 1ns/1ps
module pri_irq_agg #(
   parameter int unsigned         NUM_MODS = 8,
   parameter int unsigned         ADDR_W   = 8,
   parameter int unsigned         DATA_W   = 8,
   parameter logic [NUM_MODS-1:0] PRESENT  = 8'h7F,
   parameter logic [NUM_MODS-1:0] ONE_LINE = 8'h40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_MODS-1:0] line1_req,
   input  logic [NUM_MODS-1:0] line2_req,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                int1_n,
   output logic                int2_n
);
   import pia_pkg::*;

   localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(OFS_STAT1);
   localparam logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(OFS_STAT2);
   localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(OFS_FORCE);

   if (NUM_MODS < 1 || NUM_MODS > MAX_MODS || NUM_MODS > DATA_W) begin : g_bad_mods
      $error("pri_irq_agg: NUM_MODS out of range");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pri_irq_agg: ADDR_W too narrow for the register map");
   end

   logic [NUM_MODS-1:0] stat1, stat2, force_bits;
   logic                force_we;

   assign force_we = reg_wr && (reg_addr == A_FORCE);

   pia_force_reg #(.NUM_MODS(NUM_MODS), .DATA_W(DATA_W), .PRESENT(PRESENT)) u_force (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (force_we),
      .wdata_i (reg_wdata),
      .force_o (force_bits)
   );

   pia_line_merge #(.NUM_MODS(NUM_MODS), .PRESENT(PRESENT), .ONE_LINE(ONE_LINE)) u_merge (
      .req1_i  (line1_req),
      .req2_i  (line2_req),
      .force_i (force_bits),
      .stat1_o (stat1),
      .stat2_o (stat2)
   );

   pia_irq_out #(.NUM_MODS(NUM_MODS)) u_out1 (
      .clk (clk), .rst_n (rst_n), .stat_i (stat1), .irq_n_o (int1_n)
   );
   pia_irq_out #(.NUM_MODS(NUM_MODS)) u_out2 (
      .clk (clk), .rst_n (rst_n), .stat_i (stat2), .irq_n_o (int2_n)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STAT1)      reg_rdata[NUM_MODS-1:0] = stat1;
      else if (reg_addr == A_STAT2) reg_rdata[NUM_MODS-1:0] = stat2;
      else if (reg_addr == A_FORCE) reg_rdata[NUM_MODS-1:0] = force_bits;
   end

   // R4
   one_line_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat1 ^ stat2) & ONE_LINE) == '0);
   // R5
   absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat1 | stat2 | force_bits) & ~PRESENT) == '0);
   // R6
   force_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_bits & ~(stat1 & stat2)) == '0);
endmodule

// File: tb/tb_pri_irq_agg.sv
`timescale 1ns/1ps
module tb_pri_irq_agg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] line1_req = '0, line2_req = '0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_rdata;
   logic       int1_n, int2_n;

   int tests = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pri_irq_agg dut (
      .clk(clk), .rst_n(rst_n), .line1_req(line1_req), .line2_req(line2_req),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .int1_n(int1_n), .int2_n(int2_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_req(input logic [7:0] r1, input logic [7:0] r2);
      @(negedge clk);
      line1_req = r1; line2_req = r2;
   endtask

   // one full edge later, sampled away from the edge
   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1", "int1_n", {7'd0, int1_n}, 8'd1);
      chk("R1", "int2_n", {7'd0, int2_n}, 8'd1);
      rd(8'h03, v); chk("R1", "test reg", v, 8'h00);
      rd(8'h01, v); chk("R1", "status1", v, 8'h00);
   endtask

   task automatic t_line1();
      logic [7:0] v;
      set_req(8'h05, 8'h00);
      rd(8'h01, v); chk("R2", "status1 05", v, 8'h05);
      rd(8'h02, v); chk("R9", "status2 stays 0", v, 8'h00);
      settle();
      chk("R9", "int1_n low", {7'd0, int1_n}, 8'd0);
      chk("R9", "int2_n high", {7'd0, int2_n}, 8'd1);
      set_req(8'h21, 8'h00);
      rd(8'h01, v); chk("R2", "status1 21 live", v, 8'h21);
      set_req(8'h00, 8'h00);
      rd(8'h01, v); chk("R2", "status1 not latched", v, 8'h00);
      settle();
   endtask

   task automatic t_line2();
      logic [7:0] v;
      set_req(8'h00, 8'h0A);
      rd(8'h02, v); chk("R3", "status2 0A", v, 8'h0A);
      rd(8'h01, v); chk("R9", "status1 stays 0", v, 8'h00);
      settle();
      chk("R9", "int2_n low", {7'd0, int2_n}, 8'd0);
      chk("R9", "int1_n high", {7'd0, int1_n}, 8'd1);
      set_req(8'h00, 8'h00);
      settle();
   endtask

   task automatic t_single();
      logic [7:0] v;
      set_req(8'h40, 8'h00);
      rd(8'h01, v); chk("R4", "single on status1", v, 8'h40);
      rd(8'h02, v); chk("R4", "single mirrored to status2", v, 8'h40);
      settle();
      chk("R4", "int2_n low from line1 req", {7'd0, int2_n}, 8'd0);
      set_req(8'h00, 8'h40);
      rd(8'h02, v); chk("R4", "line2 input ignored", v, 8'h00);
      settle();
      chk("R4", "int2_n high", {7'd0, int2_n}, 8'd1);
      set_req(8'h00, 8'h00);
   endtask

   task automatic t_absent();
      logic [7:0] v;
      set_req(8'h80, 8'h80);
      rd(8'h01, v); chk("R5", "absent status1", v, 8'h00);
      rd(8'h02, v); chk("R5", "absent status2", v, 8'h00);
      settle();
      chk("R5", "int1_n high", {7'd0, int1_n}, 8'd1);
      chk("R5", "int2_n high", {7'd0, int2_n}, 8'd1);
      set_req(8'h00, 8'h00);
   endtask

   task automatic t_force();
      logic [7:0] v;
      wr(8'h03, 8'hFF);
      rd(8'h03, v); chk("R6", "test reg masked", v, 8'h7F);
      rd(8'h01, v); chk("R6", "forced status1", v, 8'h7F);
      rd(8'h02, v); chk("R6", "forced status2", v, 8'h7F);
      settle();
      chk("R6", "int1_n low", {7'd0, int1_n}, 8'd0);
      chk("R6", "int2_n low", {7'd0, int2_n}, 8'd0);
      wr(8'h03, 8'h10);
      rd(8'h01, v); chk("R6", "partial clear status1", v, 8'h10);
      rd(8'h02, v); chk("R6", "partial clear status2", v, 8'h10);
      wr(8'h03, 8'h00);
      rd(8'h03, v); chk("R6", "test reg cleared", v, 8'h00);
      settle();
      chk("R6", "int1_n released", {7'd0, int1_n}, 8'd1);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      set_req(8'h01, 8'h00);
      rd(8'h00, v); chk("R8", "offset 00", v, 8'h00);
      rd(8'h04, v); chk("R8", "offset 04", v, 8'h00);
      rd(8'hFF, v); chk("R8", "offset FF", v, 8'h00);
      wr(8'h01, 8'hFF);
      wr(8'h02, 8'hFF);
      wr(8'h07, 8'hFF);
      rd(8'h01, v); chk("R8", "status1 after writes", v, 8'h01);
      rd(8'h02, v); chk("R8", "status2 after writes", v, 8'h00);
      rd(8'h03, v); chk("R8", "test reg after writes", v, 8'h00);
      set_req(8'h00, 8'h00);
      settle();
   endtask

   task automatic t_timing();
      @(negedge clk);
      line1_req = 8'h02;
      #1 chk("R7", "int1_n before edge", {7'd0, int1_n}, 8'd1);
      settle();
      chk("R7", "int1_n after edge", {7'd0, int1_n}, 8'd0);
      @(negedge clk);
      line1_req = 8'h00;
      #1 chk("R7", "int1_n held before edge", {7'd0, int1_n}, 8'd0);
      settle();
      chk("R7", "int1_n released after edge", {7'd0, int1_n}, 8'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_line1();
      t_line2();
      t_single();
      t_absent();
      t_force();
      t_unmapped();
      t_timing();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule